// File: doc/BRIEF.md
# Coprocessor Instruction Scan Pointer

This block holds two addresses for a main processor that executes coprocessor-class instructions. The instruction address stays on the first operation word of the instruction for as long as the instruction runs. The scan address moves forward through the words that follow it, one word at a time.

A start strobe carries the operation word address and a 3-bit instruction class. The class sets how far ahead of the operation word the scan address begins. Single-cycle pulses from the effective-address logic and from coprocessor extension-word transfers each move the scan address on by one 16-bit word. A completion strobe copies the scan address into the instruction address, so that the instruction address then points at the next instruction. An illegal class code or an odd start address is refused and raises a flag.

Top module: `cp_scan_ptr`

## Requirements
- R1: While an instruction is active, `inst_addr_o` holds the start address and does not change until the completion strobe.
- R2: Each consume pulse taken while active advances `scan_addr_o` by 2 bytes; the new value shows one cycle after the pulse.
- R3: The two consume sources each count one word; pulses from both in the same cycle advance `scan_addr_o` by 4 bytes.
- R4: A completion strobe while active loads `inst_addr_o` with the scan value and clears `active_o` on the next cycle.
- R5: A start with class code 0 (general), 2 (set-on-condition), 3 (trap-on-condition) or 4 (decrement-and-branch) loads `inst_addr_o` with the start address and `scan_addr_o` with the start address plus 4.
- R6: A start with class code 1 (conditional branch) loads `scan_addr_o` with the start address plus 2.
- R7: When a consume pulse and a completion strobe arrive in the same cycle, the consumed word is added first, and the result goes to both `scan_addr_o` and `inst_addr_o`.
- R8: A start with class code 5, 6 or 7 sets `illegal_o`, does not start the instruction, and leaves both addresses unchanged.
- R9: A start whose address has bit 0 set sets `addr_err_o`, does not start the instruction, and leaves both addresses unchanged. Each start taken while idle rewrites both flags; a clean start clears both.
- R10: Consume pulses and completion strobes while idle have no effect.
- R11: A start strobe while an instruction is active is ignored.
- R12: A synchronous active-high reset clears both addresses, `active_o`, `illegal_o` and `addr_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a new instruction |
| start_addr_i | input | 32 | Operation word address given with the start strobe |
| class_i | input | 3 | Instruction class code |
| consume_ea_i | input | 1 | Word consumed by effective-address or branch-target logic |
| consume_cp_i | input | 1 | Word consumed by a coprocessor extension-word transfer |
| done_i | input | 1 | Completion strobe for the instruction |
| scan_addr_o | output | 32 | Current scan address |
| inst_addr_o | output | 32 | Instruction address |
| active_o | output | 1 | An instruction is in progress |
| illegal_o | output | 1 | The last start attempt had an illegal class code |
| addr_err_o | output | 1 | The last start attempt had an odd address |

## Verification
Every result is registered, so a strobe driven before clock edge N shows at the outputs right after edge N, with a latency of one cycle. This holds for the start load, for each consume step, for the copy on completion, and for both flags. The driver applies one stimulus per cycle at the falling edge and pushes the outputs it expects after the next rising edge. The monitor samples 2 ns after that rising edge and compares the whole output set. Each queued item is therefore checked in the one cycle where it is due, and every cycle in the sequence is checked.

// File: rtl/cp_scan_pkg.sv
package cp_scan_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_GEN     = 3'd0,
    CLS_BRANCH  = 3'd1,
    CLS_SET     = 3'd2,
    CLS_TRAP    = 3'd3,
    CLS_DBRANCH = 3'd4
  } cls_e;

  // Codes above the last defined class are illegal.
  function automatic logic cls_legal(input logic [CLS_W-1:0] c);
    return c <= CLS_DBRANCH;
  endfunction

  // Number of words between the operation word and the first scan position.
  function automatic logic [1:0] lead_words(input logic [CLS_W-1:0] c);
    return (c == CLS_BRANCH) ? 2'd1 : 2'd2;
  endfunction

  // Number of words consumed this cycle; the two sources add.
  function automatic logic [1:0] step_count(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/cp_class_decode.sv
module cp_class_decode
  import cp_scan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [CLS_W-1:0]  class_i,
  output logic              legal_o,
  output logic [ADDR_W-1:0] lead_bytes_o
);
  localparam int LEAD_W = 3;

  logic [LEAD_W-1:0] lead_b;

  always_comb begin
    legal_o      = cls_legal(class_i);
    lead_b       = {lead_words(class_i), 1'b0};
    lead_bytes_o = ADDR_W'(lead_b);
  end
endmodule

// File: rtl/cp_scan_ctrl.sv
module cp_scan_ctrl
  import cp_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       addr_lsb_i,
  input  logic       legal_i,
  input  logic       consume_ea_i,
  input  logic       consume_cp_i,
  input  logic       done_i,
  output logic       active_o,
  output logic       illegal_o,
  output logic       addr_err_o,
  output logic       ev_load_o,
  output logic       ev_done_o,
  output logic [1:0] step_words_o
);
  logic active_q, illegal_q, addr_err_q;
  logic ev_try, ev_reject;

  always_comb begin
    ev_try       = start_i && !active_q;
    ev_reject    = ev_try && (!legal_i || addr_lsb_i);
    ev_load_o    = ev_try && !ev_reject;
    ev_done_o    = active_q && done_i;
    step_words_o = active_q ? step_count(consume_ea_i, consume_cp_i) : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      illegal_q  <= 1'b0;
      addr_err_q <= 1'b0;
    end else begin
      if (ev_try) begin
        illegal_q  <= !legal_i;
        addr_err_q <= addr_lsb_i;
      end
      if (ev_load_o)      active_q <= 1'b1;
      else if (ev_done_o) active_q <= 1'b0;
    end
  end

  assign active_o   = active_q;
  assign illegal_o  = illegal_q;
  assign addr_err_o = addr_err_q;

  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ev_reject |=> !active_o); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (active_o && start_i && !done_i) |=> (active_o && $stable(illegal_o) && $stable(addr_err_o))); // R11
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (active_o && done_i) |=> !active_o); // R4
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (step_words_o == 2'd0)); // R10
endmodule

// File: rtl/cp_addr_regs.sv
module cp_addr_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [ADDR_W-1:0] lead_bytes_i,
  input  logic [1:0]        step_words_i,
  input  logic              ev_done_i,
  output logic [ADDR_W-1:0] scan_o,
  output logic [ADDR_W-1:0] inst_o
);
  localparam int STEP_W = 3;

  logic [ADDR_W-1:0] scan_q, inst_q, scan_next;
  logic [STEP_W-1:0] step_b;

  always_comb begin
    step_b    = {step_words_i, 1'b0};
    scan_next = scan_q + ADDR_W'(step_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= '0;
      inst_q <= '0;
    end else if (ev_load_i) begin
      inst_q <= load_addr_i;
      scan_q <= load_addr_i + lead_bytes_i;
    end else begin
      scan_q <= scan_next;
      if (ev_done_i) inst_q <= scan_next;
    end
  end

  assign scan_o = scan_q;
  assign inst_o = inst_q;

  AST_INST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_load_i && !ev_done_i) |=> $stable(inst_o)); // R1
  AST_COPY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (ev_done_i && !ev_load_i) |=> (inst_o == scan_o)); // R4
  AST_LEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    ev_load_i |=> ((scan_o - inst_o == ADDR_W'(2)) || (scan_o - inst_o == ADDR_W'(4)))); // R5
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_load_i && step_words_i == 2'd0) |=> $stable(scan_o)); // R10
endmodule

// File: rtl/cp_scan_ptr.sv
module cp_scan_ptr
  import cp_scan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CLS_W-1:0]  class_i,
  input  logic              consume_ea_i,
  input  logic              consume_cp_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] scan_addr_o,
  output logic [ADDR_W-1:0] inst_addr_o,
  output logic              active_o,
  output logic              illegal_o,
  output logic              addr_err_o
);
  logic              cls_ok;
  logic [ADDR_W-1:0] lead_bytes;
  logic              ev_load, ev_done;
  logic [1:0]        step_words;

  cp_class_decode #(.ADDR_W(ADDR_W)) u_dec (
    .class_i      (class_i),
    .legal_o      (cls_ok),
    .lead_bytes_o (lead_bytes)
  );

  cp_scan_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .addr_lsb_i   (start_addr_i[0]),
    .legal_i      (cls_ok),
    .consume_ea_i (consume_ea_i),
    .consume_cp_i (consume_cp_i),
    .done_i       (done_i),
    .active_o     (active_o),
    .illegal_o    (illegal_o),
    .addr_err_o   (addr_err_o),
    .ev_load_o    (ev_load),
    .ev_done_o    (ev_done),
    .step_words_o (step_words)
  );

  cp_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .ev_load_i    (ev_load),
    .load_addr_i  (start_addr_i),
    .lead_bytes_i (lead_bytes),
    .step_words_i (step_words),
    .ev_done_i    (ev_done),
    .scan_o       (scan_addr_o),
    .inst_o       (inst_addr_o)
  );

  AST_ODD_START_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_o && start_addr_i[0]) |=> (addr_err_o && !active_o)); // R9
  AST_BAD_CLASS_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_o && class_i > 3'd4) |=> (illegal_o && $stable(inst_addr_o) && $stable(scan_addr_o))); // R8
endmodule

// File: tb/cp_scan_ptr_tb.sv
`timescale 1ns/1ps
module cp_scan_ptr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [2:0]  class_i;
  logic        consume_ea_i, consume_cp_i, done_i;
  logic [31:0] scan_addr_o, inst_addr_o;
  logic        active_o, illegal_o, addr_err_o;

  always #10 clk = ~clk;

  cp_scan_ptr u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .class_i(class_i), .consume_ea_i(consume_ea_i), .consume_cp_i(consume_cp_i),
    .done_i(done_i), .scan_addr_o(scan_addr_o), .inst_addr_o(inst_addr_o),
    .active_o(active_o), .illegal_o(illegal_o), .addr_err_o(addr_err_o)
  );

  typedef struct packed {
    logic [31:0] scan;
    logic [31:0] inst;
    logic        act;
    logic        ill;
    logic        aerr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;

  logic [31:0] m_scan = '0, m_inst = '0;
  logic        m_act = 0, m_ill = 0, m_aerr = 0;

  // Driver: applies one cycle of stimulus and queues the outputs due after the next edge.
  task automatic step(input bit r, input bit st, input logic [31:0] a, input logic [2:0] c,
                      input bit ea, input bit cp, input bit dn, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; start_i = st; start_addr_i = a; class_i = c;
    consume_ea_i = ea; consume_cp_i = cp; done_i = dn;
    if (r) begin
      m_scan = '0; m_inst = '0; m_act = 0; m_ill = 0; m_aerr = 0;
    end else if (!m_act) begin
      if (st) begin
        m_ill  = (c >= 3'd5);
        m_aerr = a[0];
        if (!m_ill && !m_aerr) begin
          m_inst = a;
          m_scan = a + ((c == 3'd1) ? 32'd2 : 32'd4);
          m_act  = 1;
        end
      end
    end else begin
      if (ea) m_scan = m_scan + 32'd2;
      if (cp) m_scan = m_scan + 32'd2;
      if (dn) begin
        m_inst = m_scan;
        m_act  = 0;
      end
    end
    e.scan = m_scan; e.inst = m_inst; e.act = m_act; e.ill = m_ill; e.aerr = m_aerr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the outputs 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got.scan = scan_addr_o; got.inst = inst_addr_o; got.act = active_o;
      got.ill = illegal_o; got.aerr = addr_err_o;
      n_run++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: scan=%h inst=%h act=%0b ill=%0b aerr=%0b expected scan=%h inst=%h act=%0b ill=%0b aerr=%0b",
                 t, got.scan, got.inst, got.act, got.ill, got.aerr,
                 e.scan, e.inst, e.act, e.ill, e.aerr);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; start_i = 0; start_addr_i = '0; class_i = '0;
    consume_ea_i = 0; consume_cp_i = 0; done_i = 0;
    step(1, 0, 32'h0, 3'd0, 0, 0, 0, "R12 reset");
    step(1, 0, 32'h0, 3'd0, 1, 1, 1, "R12 reset holds");
    // General class start, then consumes and completion
    step(0, 1, 32'h0000_1000, 3'd0, 0, 0, 0, "R5 general lead");
    step(0, 0, 32'h0, 3'd0, 1, 0, 0, "R2 ea consume");
    step(0, 0, 32'h0, 3'd0, 0, 1, 0, "R2 cp consume, R1 inst held");
    step(0, 0, 32'h0, 3'd0, 0, 0, 0, "R1 quiet cycle");
    step(0, 0, 32'h0, 3'd0, 1, 1, 0, "R3 both sources");
    step(0, 1, 32'h0000_7000, 3'd1, 0, 0, 0, "R11 start while busy");
    step(0, 0, 32'h0, 3'd0, 0, 0, 1, "R4 completion copy");
    // Idle: consume and completion ignored
    step(0, 0, 32'h0, 3'd0, 1, 1, 0, "R10 idle consume");
    step(0, 0, 32'h0, 3'd0, 0, 0, 1, "R10 idle done");
    // Branch class with consume on the completion cycle
    step(0, 1, 32'h0000_2000, 3'd1, 1, 1, 1, "R6 branch lead");
    step(0, 0, 32'h0, 3'd0, 0, 1, 0, "R2 branch cp consume");
    step(0, 0, 32'h0, 3'd0, 1, 0, 1, "R7 consume with done");
    step(0, 0, 32'h0, 3'd0, 0, 0, 0, "R7 settled");
    // Other conditional classes
    step(0, 1, 32'hFFFF_FFF0, 3'd2, 0, 0, 0, "R5 set lead");
    step(0, 0, 32'h0, 3'd0, 1, 1, 1, "R7 both with done");
    step(0, 1, 32'h0001_0000, 3'd3, 0, 0, 0, "R5 trap lead");
    step(0, 0, 32'h0, 3'd0, 0, 0, 1, "R4 trap done");
    step(0, 1, 32'h0002_0000, 3'd4, 0, 0, 0, "R5 dbranch lead");
    step(0, 0, 32'h0, 3'd0, 0, 0, 1, "R4 dbranch done");
    // Illegal classes and odd addresses
    for (int k = 5; k < 8; k++)
      step(0, 1, 32'h0003_0000, 3'(k), 0, 0, 0, "R8 illegal class");
    step(0, 0, 32'h0, 3'd0, 1, 0, 0, "R8 flag holds, idle");
    step(0, 1, 32'h0004_0001, 3'd0, 0, 0, 0, "R9 odd address");
    step(0, 1, 32'h0004_0003, 3'd6, 0, 0, 0, "R9 R8 both errors");
    step(0, 1, 32'h0005_0000, 3'd1, 0, 0, 0, "R9 clean start clears flags");
    step(0, 0, 32'h0, 3'd0, 1, 0, 0, "R2 step after restart");
    step(0, 0, 32'h0, 3'd0, 0, 0, 1, "R4 final done");
    step(1, 0, 32'h0, 3'd0, 0, 0, 0, "R12 reset after use");
    step(0, 0, 32'h0, 3'd0, 0, 0, 0, "R12 idle after reset");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule